// File: doc/BRIEF.md
# Unbiased Rounding and Saturation Unit

This unit turns a wide signed accumulator value into a 16-bit rounded result held in its own result register. The accumulator is 40 bits wide. The unit keeps bits 31..16 and uses bits 15..0 to decide how to round. Rounding is round-half-to-even: a fraction above one half rounds up, and a fraction below one half rounds down. An exact half rounds toward the even neighbour, so it goes up only when bit 16 is 1.

A saturation enable picks what happens when the rounded value does not fit in the signed 16-bit range. With saturation on, the result clamps to the nearest limit. With saturation off, the result wraps. Overflow is judged on the whole 40-bit signed value after the possible +1. Its direction is taken from the accumulator's sign bit. The unit never writes the accumulator.

The surrounding datapath raises a single-cycle update strobe in three cases: when its last pipeline stage completes, after a shift, or when the lowest accumulator byte is written. On every clock edge that sees the strobe, the result register loads the new value. It keeps that value until the next strobe. Integer and fractional data are treated alike.

Top module: `rsu_round_sat`

## Requirements
- R1: While `rst` is high at a rising clock edge, `rnd_o` becomes 0x0000 after that edge.
- R2: When `acc_i[15:0]` is greater than 0x8000 and the result fits in the signed 16-bit range, the result is `acc_i[31:16] + 1`.
- R3: When `acc_i[15:0]` is less than 0x8000, the result is `acc_i[31:16]` unchanged.
- R4: When `acc_i[15:0]` equals 0x8000 and bit 16 is 1 (odd), the result is `acc_i[31:16] + 1`.
- R5: When `acc_i[15:0]` equals 0x8000 and bit 16 is 0 (even), the result is `acc_i[31:16]` unchanged.
- R6: With `sat_en_i` = 1, a rounded value above +32767 gives 0x7FFF. This includes a carry caused by the +1 itself.
- R7: With `sat_en_i` = 1, a rounded value below -32768 gives 0x8000.
- R8: With `sat_en_i` = 0, an out-of-range rounded value is not clamped. The result is the low 16 bits of the rounded value.
- R9: Without a strobe, `rnd_o` holds its value, whatever `acc_i` and `sat_en_i` do.
- R10: A result loads on the rising edge that samples `upd_i` = 1 and is visible right after that edge. Strobes on consecutive cycles each yield their own result.
- R11: With `sat_en_i` = 1, a rounded value that lands exactly on +32767 or -32768 passes through unclamped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe; loads a new rounded result |
| sat_en_i | input | 1 | 1 = clamp to the signed 16-bit limits, 0 = wrap |
| acc_i | input | 40 | Signed accumulator value; read only |
| rnd_o | output | 16 | Registered rounded (and optionally clamped) result |

## Verification
Each result is due one register stage after its strobe. It appears just after the rising edge that sampled `upd_i` high and stays until the next strobe. The driver sets inputs on falling edges and pushes the expected value for each strobe into a queue. The monitor notes the strobe at the rising edge and compares `rnd_o` against the queue at the following falling edge, so back-to-back strobes are checked one per cycle. Hold and reset checks read `rnd_o` several falling edges after the last strobe or the reset edge.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  // Classification of the rounded value against the signed result range
  typedef enum logic [1:0] {
    OVF_NONE = 2'd0,
    OVF_POS  = 2'd1,
    OVF_NEG  = 2'd2
  } ovf_kind_e;

endpackage

// File: rtl/rsu_round_decide.sv
// Round-half-to-even decision from the discarded fraction bits
module rsu_round_decide #(
  parameter int FRAC_W = 16
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              keep_lsb_i,
  output logic              up_o
);

  localparam logic [FRAC_W-1:0] HALF = {1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    if (frac_i > HALF) begin
      up_o = 1'b1;
    end else if (frac_i == HALF) begin
      up_o = keep_lsb_i;
    end else begin
      up_o = 1'b0;
    end
  end

endmodule

// File: rtl/rsu_sat_clamp.sv
// Adds the rounding increment, detects range overflow and clamps or wraps
module rsu_sat_clamp #(
  parameter int KEEP_W = 24,
  parameter int RES_W  = 16
) (
  input  logic [KEEP_W-1:0] keep_i,
  input  logic              up_i,
  input  logic              sat_en_i,
  output logic [RES_W-1:0]  res_o
);

  localparam int SUM_W  = KEEP_W + 1;
  localparam int HEAD_W = SUM_W - RES_W + 1;
  localparam logic [RES_W-1:0] MAX_POS = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] MAX_NEG = {1'b1, {(RES_W-1){1'b0}}};

  logic [SUM_W-1:0]  sum;
  logic [HEAD_W-1:0] head;
  logic              fits;
  rsu_pkg::ovf_kind_e ovf;

  // One guard bit so the largest positive input plus one cannot wrap
  assign sum  = {keep_i[KEEP_W-1], keep_i} + {{(SUM_W-1){1'b0}}, up_i};
  assign head = sum[SUM_W-1:RES_W-1];
  assign fits = (head == '0) || (head == '1);

  always_comb begin
    if (fits) begin
      ovf = rsu_pkg::OVF_NONE;
    end else if (keep_i[KEEP_W-1]) begin
      ovf = rsu_pkg::OVF_NEG;
    end else begin
      ovf = rsu_pkg::OVF_POS;
    end
  end

  always_comb begin
    res_o = sum[RES_W-1:0];
    if (sat_en_i) begin
      case (ovf)
        rsu_pkg::OVF_POS: res_o = MAX_POS;
        rsu_pkg::OVF_NEG: res_o = MAX_NEG;
        default:          res_o = sum[RES_W-1:0];
      endcase
    end
  end

endmodule

// File: rtl/rsu_round_sat.sv
// Top: rounding decision, clamp and the registered result
module rsu_round_sat #(
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 16,
  parameter int RES_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic             sat_en_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [RES_W-1:0] rnd_o
);

  localparam int KEEP_W  = ACC_W - FRAC_W;
  localparam int SIGN_LO = FRAC_W + RES_W;

  logic             round_up;
  logic [RES_W-1:0] res_next;
  logic [RES_W-1:0] res_q;

  rsu_round_decide #(
    .FRAC_W (FRAC_W)
  ) u_decide (
    .frac_i     (acc_i[FRAC_W-1:0]),
    .keep_lsb_i (acc_i[FRAC_W]),
    .up_o       (round_up)
  );

  rsu_sat_clamp #(
    .KEEP_W (KEEP_W),
    .RES_W  (RES_W)
  ) u_clamp (
    .keep_i   (acc_i[ACC_W-1:FRAC_W]),
    .up_i     (round_up),
    .sat_en_i (sat_en_i),
    .res_o    (res_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else if (upd_i) begin
      res_q <= res_next;
    end
  end

  assign rnd_o = res_q;

  // Port-level views of the high bits, used only by the checks below
  logic [ACC_W-SIGN_LO:0]   hi_pos;
  logic [ACC_W-SIGN_LO-1:0] hi_neg;
  assign hi_pos = acc_i[ACC_W-1:SIGN_LO-1];
  assign hi_neg = acc_i[ACC_W-1:SIGN_LO];

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> rnd_o == '0); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(rnd_o)); // R9

  AST_CLAMP_POS: assert property (@(posedge clk) disable iff (rst)
    (upd_i && sat_en_i && !acc_i[ACC_W-1] && hi_pos != '0)
    |=> rnd_o == {1'b0, {(RES_W-1){1'b1}}}); // R6

  AST_CLAMP_NEG: assert property (@(posedge clk) disable iff (rst)
    (upd_i && sat_en_i && acc_i[ACC_W-1] && hi_neg != '1)
    |=> rnd_o == {1'b1, {(RES_W-1){1'b0}}}); // R7

  AST_BELOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !sat_en_i && !acc_i[FRAC_W-1])
    |=> rnd_o == $past(acc_i[SIGN_LO-1:FRAC_W])); // R3

  AST_TIE_EVEN: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !sat_en_i && acc_i[FRAC_W-1:0] == {1'b1, {(FRAC_W-1){1'b0}}} && !acc_i[FRAC_W])
    |=> rnd_o == $past(acc_i[SIGN_LO-1:FRAC_W])); // R5

endmodule

// File: tb/rsu_round_sat_test.sv
`timescale 1ns/1ps
module rsu_round_sat_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_i = 1'b0;
  logic        sat_en_i = 1'b0;
  logic [39:0] acc_i = '0;
  logic [15:0] rnd_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit due     = 1'b0;
  logic [15:0] last_exp = 16'h0000;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  rsu_round_sat uut (
    .clk      (clk),
    .rst      (rst),
    .upd_i    (upd_i),
    .sat_en_i (sat_en_i),
    .acc_i    (acc_i),
    .rnd_o    (rnd_o)
  );

  function automatic logic [15:0] model(input logic [39:0] a, input logic sat);
    longint sv, kept, low, r;
    sv   = longint'(signed'(a));
    kept = sv >>> 16;
    low  = sv & 64'hFFFF;
    r    = kept;
    if (low > 64'h8000 || (low == 64'h8000 && kept[0])) r = kept + 1;
    if (sat && r > 32767)  return 16'h7FFF;
    if (sat && r < -32768) return 16'h8000;
    return r[15:0];
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rnd_o=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [39:0] a, input logic sat, input string tag);
    exp_t e;
    @(negedge clk);
    acc_i    = a;
    sat_en_i = sat;
    upd_i    = 1'b1;
    e.val    = model(a, sat);
    e.tag    = tag;
    last_exp = e.val;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    upd_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: note strobe at the rising edge, compare at the next falling edge
  always @(posedge clk) due <= upd_i && !rst;

  always @(negedge clk) begin
    if (due) begin
      if (sb.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R10: unexpected result rnd_o=%h expected=none", rnd_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rnd_o, e.val, e.tag);
      end
    end
  end

  initial begin
    logic [39:0] lfsr;
    repeat (3) @(negedge clk);
    check(rnd_o, 16'h0000, "R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check(rnd_o, 16'h0000, "R1 after reset");

    strobe(40'h00_1234_8001, 1'b0, "R2 above half");
    strobe(40'h00_1234_7FFF, 1'b0, "R3 below half");
    strobe(40'h00_1235_8000, 1'b0, "R4 tie odd");
    strobe(40'h00_1234_8000, 1'b0, "R5 tie even");
    strobe(40'hFF_FFFF_8000, 1'b0, "R4 tie odd negative");
    strobe(40'hFF_FFFE_8000, 1'b0, "R5 tie even negative");
    strobe(40'hFF_FFF0_C000, 1'b1, "R2 above half negative");
    idle(2);

    strobe(40'h01_0000_0000, 1'b1, "R6 positive clamp");
    strobe(40'h00_7FFF_8001, 1'b1, "R6 clamp from increment");
    strobe(40'h7F_FFFF_FFFF, 1'b1, "R6 largest input");
    strobe(40'hFF_7FFF_0000, 1'b1, "R7 negative clamp");
    strobe(40'h80_0000_0000, 1'b1, "R7 most negative input");
    strobe(40'h01_0000_0000, 1'b0, "R8 wrap positive");
    strobe(40'h00_7FFF_8001, 1'b0, "R8 wrap from increment");
    strobe(40'hFF_7FFF_0000, 1'b0, "R8 wrap negative");
    strobe(40'h00_7FFF_7FFF, 1'b1, "R11 lands on max");
    strobe(40'h00_7FFE_FFFF, 1'b1, "R11 rounds onto max");
    strobe(40'hFF_8000_0000, 1'b1, "R11 lands on min");
    strobe(40'hFF_7FFF_FFFF, 1'b1, "R11 rounds onto min");
    idle(2);

    // Hold: inputs move without a strobe
    acc_i = 40'h12_3456_789A;
    sat_en_i = 1'b1;
    repeat (2) @(negedge clk);
    acc_i = 40'hFF_0000_0001;
    sat_en_i = 1'b0;
    repeat (2) @(negedge clk);
    check(rnd_o, last_exp, "R9 hold without strobe");

    // Back-to-back pseudo-random strobes
    lfsr = 40'hA5_5A3C_C3E1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[38:0], lfsr[39] ^ lfsr[37] ^ lfsr[20] ^ lfsr[18]};
      strobe(lfsr, lfsr[5], "R10 consecutive strobes");
    end
    idle(3);
    check(rnd_o, last_exp, "R9 hold after burst");

    // Reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(rnd_o, 16'h0000, "R1 mid-run reset");
    rst = 1'b0;
    @(negedge clk);
    check(rnd_o, 16'h0000, "R1 stays clear");
    if (sb.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL R10: %0d results missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule